// File: doc/BRIEF.md
# Serial Address and Segment Word Loader

This block sits at the serial input of a dot-matrix LCD driver and builds parallel words from a bit stream. Four external pins arrive without a clock relationship to the chip: serial data, a shift clock, a latch strobe and a mode select. The block samples all four into the system clock domain and acts on the edges it detects there. On each rising edge of the shift clock it shifts the current data bit, most significant bit first, into one of two shift registers. The mode select picks the register: an 8-bit row address register or a 64-bit segment register.

A level-sensitive holding stage follows each shift register. While the latch strobe is high, the holding register for the selected mode follows its shift register. When the strobe drops, the holding register keeps its last value. A falling strobe in segment mode also raises a single-cycle write request toward display RAM. During that cycle the held row address and the held segment word are on the outputs. The display RAM and all analogue LCD drive are outside this block.

Top module: `serial_word_loader`

## Requirements
- R1: Each external pin resets to a synchronised level of 1, the level the pin has when it is idle. With all pins held at 1 after reset, no shift takes place, no write request is raised and both outputs stay zero.
- R2: Only a rising edge of the shift clock shifts a bit. A falling edge leaves both shift registers unchanged.
- R3: When the mode select is 1, the data bit enters the 8-bit address register at bit 0 and earlier bits move toward the MSB. When the mode select is 0, the bit enters the 64-bit segment register in the same way. The register that is not selected keeps its contents.
- R4: While the latch strobe is high, the holding register for the selected mode follows its shift register within four system clock cycles of a change.
- R5: While the latch strobe is low, neither holding register changes, even if more bits are shifted.
- R6: A falling edge of the latch strobe while the mode select is 0 gives exactly one cycle of `ram_we_o`, with the held address and held segment word on the outputs. A falling edge while the mode select is 1 gives no write request.
- R7: If fewer bits than a full word are shifted before latching, the shift register keeps the older bits moved up by the number of new bits. No error is signalled.
- R8: A synchronous active-high reset clears both shift registers and both holding registers to zero and keeps `ram_we_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_data_i | input | 1 | Serial data pin (asynchronous) |
| ser_clk_i | input | 1 | Shift clock pin (asynchronous) |
| latch_i | input | 1 | Latch strobe pin, level-sensitive (asynchronous) |
| mode_i | input | 1 | Mode select pin: 1 = row address, 0 = segment word |
| row_addr_o | output | ADDR_W | Held row address |
| seg_word_o | output | SEG_W | Held segment word |
| ram_we_o | output | 1 | Single-cycle write request to display RAM |

## Verification
The bench uses the default sizes: an 8-bit address, a 64-bit segment word and two synchroniser stages. With these sizes a full segment load moves a distinct bit pattern through every bit position, so a mistake in shift order or in the width of either word shows up directly. A partial load of three or four bits leaves older bits visible in the upper positions, which checks the short-word behaviour. A scoreboard queue pairs each expected write with the write request the design actually raises.

// File: rtl/swl_pkg.sv
package swl_pkg;
  typedef enum logic {
    MODE_SEG  = 1'b0,
    MODE_ADDR = 1'b1
  } load_mode_e;

  localparam int PIN_DATA  = 0;
  localparam int PIN_SCLK  = 1;
  localparam int PIN_LATCH = 2;
  localparam int PIN_MODE  = 3;
  localparam int PIN_COUNT = 4;
endpackage

// File: rtl/swl_pin_sync.sv
module swl_pin_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [WIDTH-1:0]             prev_q;

  // Reset to 1: an idle pin is high, so no false edge leaves reset
  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
      prev_q  <= '1;
    end else begin
      chain_q[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;
  assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/swl_shreg.sv
module swl_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         bit_i,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (shift_en) q <= {q[W-2:0], bit_i};
  end
endmodule

// File: rtl/swl_hold.sv
module swl_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         follow,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Clock-domain stand-in for a level latch: tracks d while follow is high
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (follow) q <= d;
  end
endmodule

// File: rtl/serial_word_loader.sv
module serial_word_loader
  import swl_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SEG_W       = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_data_i,
  input  logic              ser_clk_i,
  input  logic              latch_i,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] row_addr_o,
  output logic [SEG_W-1:0]  seg_word_o,
  output logic              ram_we_o
);
  logic [PIN_COUNT-1:0] pins, lvl, rise, fall;
  logic data_lvl, sclk_rise, latch_lvl, latch_fall, sel_lvl;
  load_mode_e mode;
  logic [ADDR_W-1:0] addr_sr;
  logic [SEG_W-1:0]  seg_sr;

  always_comb begin
    pins            = '0;
    pins[PIN_DATA]  = ser_data_i;
    pins[PIN_SCLK]  = ser_clk_i;
    pins[PIN_LATCH] = latch_i;
    pins[PIN_MODE]  = mode_i;
  end

  swl_pin_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .pin_i(pins),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  assign data_lvl   = lvl[PIN_DATA];
  assign sclk_rise  = rise[PIN_SCLK];
  assign latch_lvl  = lvl[PIN_LATCH];
  assign latch_fall = fall[PIN_LATCH];
  assign sel_lvl    = lvl[PIN_MODE];
  assign mode       = load_mode_e'(sel_lvl);

  logic unused_evt;
  assign unused_evt = ^{rise[PIN_DATA], rise[PIN_LATCH], rise[PIN_MODE],
                        fall[PIN_DATA], fall[PIN_SCLK], fall[PIN_MODE], lvl[PIN_SCLK]};

  swl_shreg #(.W(ADDR_W)) addr_sr_i (
    .clk(clk), .rst(rst), .shift_en(sclk_rise && mode == MODE_ADDR),
    .bit_i(data_lvl), .q(addr_sr)
  );

  swl_shreg #(.W(SEG_W)) seg_sr_i (
    .clk(clk), .rst(rst), .shift_en(sclk_rise && mode == MODE_SEG),
    .bit_i(data_lvl), .q(seg_sr)
  );

  swl_hold #(.W(ADDR_W)) addr_hold_i (
    .clk(clk), .rst(rst), .follow(latch_lvl && mode == MODE_ADDR),
    .d(addr_sr), .q(row_addr_o)
  );

  swl_hold #(.W(SEG_W)) seg_hold_i (
    .clk(clk), .rst(rst), .follow(latch_lvl && mode == MODE_SEG),
    .d(seg_sr), .q(seg_word_o)
  );

  always_ff @(posedge clk) begin
    if (rst) ram_we_o <= 1'b0;
    else     ram_we_o <= latch_fall && mode == MODE_SEG;
  end
endmodule

// File: rtl/swl_checker.sv
module swl_checker #(
  parameter int ADDR_W = 8,
  parameter int SEG_W  = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              latch_q,
  input logic              sel_q,
  input logic [ADDR_W-1:0] row_addr,
  input logic [SEG_W-1:0]  seg_word,
  input logic              ram_we
);
  // R6: a write request lasts one cycle
  p_we_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> !ram_we);
  // R6: a write request follows a latch fall seen in segment mode
  p_we_seg_mode_r6: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ($past(!sel_q) && $past(!latch_q)));
  // R5: a low strobe freezes both holding registers
  p_addr_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    !latch_q |=> $stable(row_addr));
  p_seg_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    !latch_q |=> $stable(seg_word));
  // R3: only the holding register of the selected mode may move
  p_addr_other_mode_r3: assert property (@(posedge clk) disable iff (rst)
    !sel_q |=> $stable(row_addr));
  p_seg_other_mode_r3: assert property (@(posedge clk) disable iff (rst)
    sel_q |=> $stable(seg_word));
  // R8: reset clears the outputs
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (row_addr == '0 && seg_word == '0 && !ram_we));
endmodule

bind serial_word_loader swl_checker #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) chk_i (
  .clk(clk), .rst(rst), .latch_q(latch_lvl), .sel_q(sel_lvl),
  .row_addr(row_addr_o), .seg_word(seg_word_o), .ram_we(ram_we_o)
);

// File: tb/serial_word_loader_tb_top.sv
module serial_word_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int SW = 64;
  localparam int GAP = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sdat = 1'b1, sclk = 1'b1, latch = 1'b1, mode = 1'b1;
  logic [AW-1:0] row_addr;
  logic [SW-1:0] seg_word;
  logic ram_we;

  int n_checks = 0;
  int n_fail = 0;
  int n_pulses = 0;
  int n_expected = 0;
  bit finished = 1'b0;

  typedef struct packed { logic [AW-1:0] a; logic [SW-1:0] s; } wr_item_t;
  wr_item_t exp_q[$];

  logic [AW-1:0] m_addr = '0;
  logic [SW-1:0] m_seg  = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_word_loader #(.ADDR_W(AW), .SEG_W(SW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .ser_data_i(sdat), .ser_clk_i(sclk),
    .latch_i(latch), .mode_i(mode),
    .row_addr_o(row_addr), .seg_word_o(seg_word), .ram_we_o(ram_we)
  );

  task automatic check(input bit ok, input string req, input logic [SW-1:0] act,
                       input logic [SW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Drives one bit and updates the reference shift model
  task automatic shift_bit(input logic b);
    sdat = b;
    sclk = 1'b0;
    wait_cyc(GAP);
    sclk = 1'b1;
    wait_cyc(GAP);
    if (mode) m_addr = {m_addr[AW-2:0], b};
    else      m_seg  = {m_seg[SW-2:0], b};
  endtask

  task automatic shift_word(input logic [SW-1:0] v, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) shift_bit(v[i]);
  endtask

  task automatic set_latch(input logic v);
    if (!v && latch && !mode) begin
      exp_q.push_back('{a: row_addr, s: m_seg});
      n_expected++;
    end
    latch = v;
    wait_cyc(GAP);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && ram_we) begin
      wr_item_t it;
      n_pulses++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected write", SW'(row_addr), '0);
      end else begin
        it = exp_q.pop_front();
        check(row_addr == it.a, "R6 write address", SW'(row_addr), SW'(it.a));
        check(seg_word == it.s, "R6 write segment", seg_word, it.s);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int p0;
    wait_cyc(4);
    rst = 1'b0;
    wait_cyc(1);
    // R8: reset state
    check(row_addr == '0 && seg_word == '0 && !ram_we, "R8 reset state",
          seg_word, '0);
    // R1: idle pins do nothing
    wait_cyc(20);
    check(n_pulses == 0 && row_addr == '0 && seg_word == '0, "R1 idle pins",
          SW'(n_pulses), '0);

    // Address load with strobe low
    set_latch(1'b0);
    shift_word(64'hA5, 8);
    check(row_addr == '0, "R5 address held while strobe low", SW'(row_addr), '0);
    p0 = n_pulses;
    set_latch(1'b1);
    check(row_addr == 8'hA5, "R3 address MSB first", SW'(row_addr), 64'hA5);
    set_latch(1'b0);
    check(n_pulses == p0, "R6 no write in address mode", SW'(n_pulses), SW'(p0));
    check(row_addr == 8'hA5, "R5 address kept after fall", SW'(row_addr), 64'hA5);

    // Partial address load
    shift_word(64'h5, 3);
    check(row_addr == 8'hA5, "R5 extra bits do not reach hold", SW'(row_addr), 64'hA5);
    set_latch(1'b1);
    check(row_addr == 8'h2D, "R7 partial address", SW'(row_addr), 64'h2D);

    // Transparency and edge polarity with strobe high
    sdat = 1'b1;
    sclk = 1'b0;
    wait_cyc(GAP);
    check(row_addr == 8'h2D, "R2 falling shift clock ignored", SW'(row_addr), 64'h2D);
    sclk = 1'b1;
    wait_cyc(GAP);
    m_addr = {m_addr[AW-2:0], 1'b1};
    check(row_addr == 8'h5B, "R4 hold follows while strobe high", SW'(row_addr), 64'h5B);
    set_latch(1'b0);

    // Segment loads
    mode = 1'b0;
    wait_cyc(GAP);
    shift_word(64'h0123_4567_89AB_CDEF, 64);
    check(seg_word == '0, "R5 segment held while strobe low", seg_word, '0);
    set_latch(1'b1);
    check(seg_word == 64'h0123_4567_89AB_CDEF, "R3 segment MSB first", seg_word,
          64'h0123_4567_89AB_CDEF);
    p0 = n_pulses;
    set_latch(1'b0);
    check(n_pulses == p0 + 1, "R6 one write per fall", SW'(n_pulses), SW'(p0 + 1));

    shift_word(64'hF00D_1234_C0DE_8765, 64);
    set_latch(1'b1);
    set_latch(1'b0);
    shift_word(64'h9, 4);
    set_latch(1'b1);
    check(seg_word == m_seg, "R7 partial segment", seg_word, m_seg);
    set_latch(1'b0);

    // Address register untouched by segment shifting
    mode = 1'b1;
    wait_cyc(GAP);
    set_latch(1'b1);
    check(row_addr == 8'h5B, "R3 address kept during segment load", SW'(row_addr), 64'h5B);
    set_latch(1'b0);

    // Reset mid-run with idle pins
    mode = 1'b1; latch = 1'b1; sclk = 1'b1; sdat = 1'b1;
    wait_cyc(GAP);
    rst = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
    check(row_addr == '0 && seg_word == '0 && !ram_we, "R8 reset clears holds",
          seg_word, '0);
    m_addr = '0;
    m_seg  = '0;
    set_latch(1'b0);
    mode = 1'b0;
    wait_cyc(GAP);
    shift_word(64'hF, 4);
    set_latch(1'b1);
    check(seg_word == 64'hF, "R8 reset clears shift register", seg_word, 64'hF);
    set_latch(1'b0);
    mode = 1'b1;
    wait_cyc(GAP);

    check(exp_q.size() == 0 && n_pulses == n_expected, "R6 all writes seen",
          SW'(n_pulses), SW'(n_expected));
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule